// File: doc/BRIEF.md
# Two-Stage Precharged SRAM Cycle Driver with Data Checker

This block turns a single memory request into a complete bus cycle for a static RAM that needs its bit lines precharged before each access. The request carries an address, a 32-bit word, a parity bit and a write flag, and arrives on a valid/ready handshake. Every cycle has two stages. The first stage precharges the array. The second stage enables the access and raises the strobe for the requested operation. The address and any write data stay fixed for the whole cycle.

The block samples the 33 data lanes at the end of the second stage. Lanes 0 to 31 hold the word and lane 32 holds the parity bit. The sampled value is compared with the word and parity of the request. Each lane that differs is sent out on an error stream, one lane per clock. Each report gives the location, the lane index and whether the cycle was a write or a read. A test sequencer uses the block to march patterns through a memory and to find failing cells.

The data bus has three signals: a 33-bit value out, an output enable, and a 33-bit sampled value in. The chip-level pad ring builds the actual tri-state bus from them.

Top module: `sram_cycle_engine`

## Requirements
- R1: While reset is held and in the first cycle after it, both strobes are low, precharge is high, access is low, the data output enable is low, no error is reported, and the request ready is high.
- R2: In the clock after a request is accepted (valid and ready both high at an edge), the cycle is in its first stage: precharge low, access low, write strobe low, read strobe low.
- R3: In the clock after the first stage, precharge and access are both high. The write strobe is high for a write request and the read strobe is high for a read request, never both.
- R4: The address pins equal the accepted request address in both stages of the cycle.
- R5: During a read cycle the data output enable is low in both stages. During a write cycle it is high in both stages, and the lanes carry the data bits on lanes 0 to 31 and the parity bit on lane 32.
- R6: Outside a cycle (idle) both strobes are low, precharge is high, access is low and the data output enable is low.
- R7: The data lanes are sampled at the clock edge that ends the second stage. Starting in the clock after that edge, each lane whose sample differs from the expected request value is reported. There is one report per clock, in ascending lane order. Each report carries the cycle address and a flag that is 1 for a write cycle and 0 for a read cycle.
- R8: The parity lane is checked like a data lane and is reported as lane index 32.
- R9: A cycle with no differing lane produces no error report. Requests are not accepted (ready low) while error reports are still pending.
- R10: Values on the data lanes during the first stage or while idle never cause an error report.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 11 | Request location |
| req_data | input | 32 | Write word, or expected word for a read |
| req_parity | input | 1 | Write parity, or expected parity for a read |
| req_write | input | 1 | 1 = write cycle, 0 = read cycle |
| mem_addr | output | 11 | RAM address pins |
| mem_dq_out | output | 33 | Lane values driven to the RAM (lane 32 = parity) |
| mem_dq_oe | output | 1 | Drive enable for the data lanes |
| mem_dq_in | input | 33 | Lane values sampled from the RAM |
| mem_precharge | output | 1 | Precharge control, low in the first stage |
| mem_access | output | 1 | Access enable, high in the second stage |
| mem_write_stb | output | 1 | Active-high write strobe |
| mem_read_stb | output | 1 | Active-high read strobe |
| err_valid | output | 1 | One mismatching lane is being reported |
| err_addr | output | 11 | Address of the failing cycle |
| err_lane | output | 6 | Failing lane index, 0 to 32 |
| err_write | output | 1 | 1 if the failing cycle was a write |

## Verification
Take an accepted request at edge N. The first-stage pin values appear in the clock after edge N, and the second-stage values one clock later. The first error report is due in the clock after the sampling edge, which is three clocks after acceptance, and each further report follows one clock apart. The bench drives inputs and samples outputs on falling edges, and it walks the stages exactly in this order. A bench RAM model feeds back the written contents. Mismatches are injected as a per-lane flip mask. The mask can be applied in the first stage or the second stage separately, so the bench knows which lanes must be reported, and in what order, before it reads the error stream.

// File: rtl/sram_cyc_pkg.sv
package sram_cyc_pkg;

    parameter int ADDR_W = 11;
    parameter int DATA_W = 32;
    localparam int LANES = DATA_W + 1;
    localparam int LANE_W = $clog2(LANES);

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_PRE  = 2'd1,
        PH_ACC  = 2'd2
    } phase_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              parity;
        logic              write;
    } mem_req_t;

    // Lane image of a request: parity sits above the data word
    function automatic logic [LANES-1:0] lane_image(input mem_req_t r);
        return {r.parity, r.data};
    endfunction

    // Index of the lowest set lane
    function automatic logic [LANE_W-1:0] lowest_lane(input logic [LANES-1:0] v);
        logic [LANE_W-1:0] idx;
        idx = '0;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (v[i]) idx = LANE_W'(i);
        end
        return idx;
    endfunction

endpackage

// File: rtl/sram_phase_seq.sv
module sram_phase_seq
    import sram_cyc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     req_valid,
    input  mem_req_t req_in,
    input  logic     scan_busy,
    output logic     req_ready,
    output phase_e   phase,
    output mem_req_t cur_req
);

    phase_e phase_q;
    mem_req_t req_q;
    logic accept;

    assign req_ready = (phase_q == PH_IDLE) && !scan_busy;
    assign accept = req_valid && req_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            req_q   <= '0;
        end else begin
            unique case (phase_q)
                PH_IDLE: if (accept) begin
                    phase_q <= PH_PRE;
                    req_q   <= req_in;
                end
                PH_PRE:  phase_q <= PH_ACC;
                PH_ACC:  phase_q <= PH_IDLE;
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign phase = phase_q;
    assign cur_req = req_q;

endmodule

// File: rtl/sram_pin_drive.sv
module sram_pin_drive
    import sram_cyc_pkg::*;
(
    input  phase_e            phase,
    input  mem_req_t          cur_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [LANES-1:0]  mem_dq_out,
    output logic              mem_dq_oe,
    output logic              mem_precharge,
    output logic              mem_access,
    output logic              mem_write_stb,
    output logic              mem_read_stb
);

    logic in_cycle;

    assign in_cycle = (phase == PH_PRE) || (phase == PH_ACC);
    assign mem_addr = cur_req.addr;
    assign mem_dq_out = lane_image(cur_req);

    always_comb begin
        mem_dq_oe     = in_cycle && cur_req.write;
        mem_precharge = 1'b1;
        mem_access    = 1'b0;
        mem_write_stb = 1'b0;
        mem_read_stb  = 1'b0;
        unique case (phase)
            PH_PRE: mem_precharge = 1'b0;
            PH_ACC: begin
                mem_access    = 1'b1;
                mem_write_stb = cur_req.write;
                mem_read_stb  = !cur_req.write;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/sram_err_scan.sv
module sram_err_scan
    import sram_cyc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [LANES-1:0]  miss_lanes,
    input  logic [ADDR_W-1:0] cap_addr,
    input  logic              cap_write,
    output logic              busy,
    output logic              err_valid,
    output logic [ADDR_W-1:0] err_addr,
    output logic [LANE_W-1:0] err_lane,
    output logic              err_write
);

    logic [LANES-1:0]  pend_q;
    logic [ADDR_W-1:0] addr_q;
    logic              write_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q  <= '0;
            addr_q  <= '0;
            write_q <= 1'b0;
        end else if (capture) begin
            pend_q  <= miss_lanes;
            addr_q  <= cap_addr;
            write_q <= cap_write;
        end else if (pend_q != '0) begin
            pend_q <= pend_q & (pend_q - LANES'(1));
        end
    end

    assign busy      = (pend_q != '0);
    assign err_valid = busy;
    assign err_addr  = addr_q;
    assign err_lane  = lowest_lane(pend_q);
    assign err_write = write_q;

endmodule

// File: rtl/sram_cycle_engine.sv
module sram_cycle_engine
    import sram_cyc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic              req_parity,
    input  logic              req_write,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [LANES-1:0]  mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [LANES-1:0]  mem_dq_in,
    output logic              mem_precharge,
    output logic              mem_access,
    output logic              mem_write_stb,
    output logic              mem_read_stb,
    output logic              err_valid,
    output logic [ADDR_W-1:0] err_addr,
    output logic [LANE_W-1:0] err_lane,
    output logic              err_write
);

    mem_req_t req_in;
    mem_req_t cur_req;
    phase_e   phase;
    logic     scan_busy;
    logic     strobe_on;
    logic     capture;
    logic [LANES-1:0] miss_lanes;

    assign req_in = '{addr: req_addr, data: req_data, parity: req_parity, write: req_write};

    sram_phase_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_in    (req_in),
        .scan_busy (scan_busy),
        .req_ready (req_ready),
        .phase     (phase),
        .cur_req   (cur_req)
    );

    sram_pin_drive u_pins (
        .phase         (phase),
        .cur_req       (cur_req),
        .mem_addr      (mem_addr),
        .mem_dq_out    (mem_dq_out),
        .mem_dq_oe     (mem_dq_oe),
        .mem_precharge (mem_precharge),
        .mem_access    (mem_access),
        .mem_write_stb (mem_write_stb),
        .mem_read_stb  (mem_read_stb)
    );

    // Compare only when a strobe is up in the second stage
    assign strobe_on  = mem_write_stb || mem_read_stb;
    assign capture    = (phase == PH_ACC);
    assign miss_lanes = strobe_on ? (mem_dq_in ^ lane_image(cur_req)) : '0;

    sram_err_scan u_scan (
        .clk        (clk),
        .rst        (rst),
        .capture    (capture),
        .miss_lanes (miss_lanes),
        .cap_addr   (cur_req.addr),
        .cap_write  (cur_req.write),
        .busy       (scan_busy),
        .err_valid  (err_valid),
        .err_addr   (err_addr),
        .err_lane   (err_lane),
        .err_write  (err_write)
    );

endmodule

// File: rtl/sram_cycle_engine_chk.sv
module sram_cycle_engine_chk
    import sram_cyc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_dq_oe,
    input logic              mem_precharge,
    input logic              mem_access,
    input logic              mem_write_stb,
    input logic              mem_read_stb,
    input logic              err_valid
);

    assert_stage1_after_accept_R2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (!mem_precharge && !mem_access && !mem_write_stb && !mem_read_stb));

    assert_stage2_follows_R3: assert property (@(posedge clk) disable iff (rst)
        !mem_precharge |=> (mem_precharge && mem_access && (mem_write_stb != mem_read_stb)));

    assert_strobes_exclusive_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_write_stb, mem_read_stb}));

    assert_addr_held_R4: assert property (@(posedge clk) disable iff (rst)
        !mem_precharge |=> $stable(mem_addr));

    assert_read_undriven_R5: assert property (@(posedge clk) disable iff (rst)
        mem_read_stb |-> !mem_dq_oe);

    assert_idle_strobes_low_R6: assert property (@(posedge clk) disable iff (rst)
        !mem_access |-> (!mem_write_stb && !mem_read_stb));

    assert_hold_while_reporting_R9: assert property (@(posedge clk) disable iff (rst)
        err_valid |-> !req_ready);

endmodule

bind sram_cycle_engine sram_cycle_engine_chk u_chk (.*);

// File: tb/test_sram_cycle_engine.sv
module test_sram_cycle_engine;
    import sram_cyc_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_data = '0;
    logic req_parity = 1'b0;
    logic req_write = 1'b0;
    logic [ADDR_W-1:0] mem_addr;
    logic [LANES-1:0] mem_dq_out;
    logic mem_dq_oe;
    logic [LANES-1:0] mem_dq_in;
    logic mem_precharge, mem_access, mem_write_stb, mem_read_stb;
    logic err_valid;
    logic [ADDR_W-1:0] err_addr;
    logic [LANE_W-1:0] err_lane;
    logic err_write;

    logic [LANES-1:0] ram [2**ADDR_W];
    logic [LANES-1:0] flip = '0;
    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sram_cycle_engine i_sram_cycle_engine (.*);

    // RAM model with lane flip injection
    assign mem_dq_in = (mem_dq_oe ? mem_dq_out : ram[mem_addr]) ^ flip;
    always @(posedge clk) if (mem_write_stb) ram[mem_addr] <= mem_dq_out;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One full cycle, checked stage by stage and through its error stream
    task automatic run_cycle(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                             input logic p, input logic wr,
                             input logic [LANES-1:0] flip_pre, input logic [LANES-1:0] flip_acc);
        logic [LANES-1:0] img;
        img = {p, d};
        req_addr = a; req_data = d; req_parity = p; req_write = wr; req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        flip = flip_pre;
        chk(!mem_precharge && !mem_access, "R2 stage1 pre/acc", {mem_precharge, mem_access}, 0);
        chk(!mem_write_stb && !mem_read_stb, "R2 stage1 strobes", {mem_write_stb, mem_read_stb}, 0);
        chk(mem_addr == a, "R4 stage1 addr", mem_addr, a);
        chk(mem_dq_oe == wr, "R5 stage1 oe", mem_dq_oe, wr);
        if (wr) chk(mem_dq_out == img, "R5 stage1 lanes", mem_dq_out, img);
        @(negedge clk);
        flip = flip_acc;
        chk(mem_precharge && mem_access, "R3 stage2 pre/acc", {mem_precharge, mem_access}, 2'b11);
        chk({mem_write_stb, mem_read_stb} == {wr, !wr}, "R3 stage2 strobes",
            {mem_write_stb, mem_read_stb}, {wr, !wr});
        chk(mem_addr == a, "R4 stage2 addr", mem_addr, a);
        chk(mem_dq_oe == wr, "R5 stage2 oe", mem_dq_oe, wr);
        if (wr) chk(mem_dq_out == img, "R5 stage2 lanes", mem_dq_out, img);
        @(negedge clk);
        flip = '0;
        for (int i = 0; i < LANES; i++) begin
            if (flip_acc[i]) begin
                chk(err_valid == 1'b1, "R7 report present", err_valid, 1);
                chk(err_lane == LANE_W'(i), (i == LANES - 1) ? "R8 parity lane" : "R7 lane order",
                    err_lane, i);
                chk(err_addr == a, "R7 report addr", err_addr, a);
                chk(err_write == wr, "R7 report kind", err_write, wr);
                chk(!req_ready, "R9 ready held low", req_ready, 0);
                @(negedge clk);
            end
        end
        chk(err_valid == 1'b0, (flip_acc == '0) ? "R9 R10 no report" : "R7 stream ends",
            err_valid, 0);
        chk(!mem_write_stb && !mem_read_stb && mem_precharge && !mem_access && !mem_dq_oe,
            "R6 idle pins",
            {mem_write_stb, mem_read_stb, mem_precharge, mem_access, mem_dq_oe}, 5'b00100);
        chk(req_ready, "R9 ready after stream", req_ready, 1);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk(!mem_write_stb && !mem_read_stb, "R1 strobes in reset", {mem_write_stb, mem_read_stb}, 0);
        chk(mem_precharge && !mem_access, "R1 pre/acc in reset", {mem_precharge, mem_access}, 2'b10);
        chk(!mem_dq_oe && !err_valid, "R1 oe/err in reset", {mem_dq_oe, err_valid}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready, "R1 ready after reset", req_ready, 1);
        chk(mem_precharge && !mem_access && !mem_dq_oe, "R6 idle after reset",
            {mem_precharge, mem_access, mem_dq_oe}, 3'b100);
    endtask

    task automatic t_idle_noise();
        flip = '1;
        repeat (3) @(negedge clk);
        flip = '0;
        @(negedge clk);
        chk(!err_valid, "R10 idle lane noise", err_valid, 0);
    endtask

    initial begin
        for (int i = 0; i < 2**ADDR_W; i++) ram[i] = '0;
        t_reset();
        t_idle_noise();
        run_cycle(11'h2A5, 32'hDEAD_BEEF, 1'b1, 1'b1, '0, '0);
        run_cycle(11'h2A5, 32'hDEAD_BEEF, 1'b1, 1'b0, '0, '0);
        run_cycle(11'h000, 32'h1234_5678, 1'b0, 1'b1, '0, '0);
        run_cycle(11'h000, 32'h1234_5678, 1'b0, 1'b0, '0, '0);
        run_cycle(11'h2A5, 32'hDEAD_BEEF, 1'b1, 1'b0, '0, 33'h1_0000_0005);
        run_cycle(11'h7FF, 32'h0000_0000, 1'b0, 1'b1, '0, 33'h0_8000_0000);
        run_cycle(11'h7FF, 32'h0000_0000, 1'b0, 1'b0, '1, '0);
        run_cycle(11'h000, 32'h1234_5678, 1'b0, 1'b0, '0, 33'h1_0000_0000);
        run_cycle(11'h400, 32'hFFFF_FFFF, 1'b1, 1'b1, '1, 33'h0_0000_0001);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule